// File: doc/BRIEF.md
# Power-Save Processor Clock Generator

This block produces the processor clock of an embedded CPU and two external clock outputs. All of them come from one PLL-rate source. The block runs on a single clock `clk` at twice the PLL frequency. The PLL-rate clock is rebuilt as a register that toggles on every `clk` edge, so every waveform it produces is a registered level. The processor clock is never handed out as a real clock. The core and its peripherals receive it as `cpu_ce`, a one-cycle enable that marks each rising edge of the processor clock.

Software enters power-save by pulsing `ps_set`. The processor clock then slows to the PLL rate divided by a power of two between 2 and 128, chosen by `div_sel`. An interrupt arriving during power-save is remembered. The block drops back to full rate on its own, at the first processor-clock rising edge that starts a T3 bus state. Each clock output picks either the PLL-rate clock or the processor clock and has its own drive enable. One output can therefore run at PLL rate while the other follows the slowed processor clock. A mode, divisor, source or enable change only takes effect on a processor-clock rising edge, so no output ever shows a shortened high or low phase.

Top module: `psave_clkgen`

## Requirements
- R1: While `rst_n` is low, `cpu_ce` and both `clk_out` bits are 0. After release the block is out of power-save, and `cpu_ce` pulses every 2 `clk` cycles.
- R2: Outside power-save the processor clock runs at PLL rate: high for 1 cycle and low for 1 cycle. An enabled output with `out_pll[i]`=0 shows this waveform, and it is high exactly in the cycles where `cpu_ce` is 1.
- R3: In power-save the divisor is D = 2^(`div_sel`+1) for `div_sel` 0 to 6, and D = 128 for `div_sel` 7. `cpu_ce` pulses every 2·D cycles. The processor clock is high for the first D cycles of each period, starting with the `cpu_ce` cycle, and low for the other D cycles.
- R4: A new `div_sel` value or a `ps_set` pulse never changes the period already running. It takes effect from the next processor-clock rising edge.
- R5: An `irq` pulse during power-save is held pending. Power-save ends at the first period boundary where `bus_t3` is 1 in the last cycle of the ending period. From the next `cpu_ce` onward, periods are 2 cycles, and they stay 2 cycles after `irq` and `bus_t3` fall.
- R6: An `irq` that arrives outside power-save is not remembered. It causes no exit after a later `ps_set`, even while `bus_t3` stays 1.
- R7: If a `ps_set` pulse falls in the same cycle as an exit, the set wins. Power-save stays on, the pending interrupt is cleared, and the following periods keep the divided length.
- R8: When `out_pll[i]`=1 and the output is enabled, `clk_out[i]` toggles on every cycle (PLL rate). This holds while the other output follows the divided processor clock at the same time.
- R9: `out_en[i]`=0 holds `clk_out[i]` at 0. `out_en` and `out_pll` are sampled only in the last cycle of a processor period, so a change made in mid-period leaves the current phase untouched.
- R10: `cpu_ce` is never high in two consecutive cycles. It is high only when the PLL-rate phase is high, and it pulses at least once every 256 cycles: the clock never stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the PLL frequency |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ps_set | input | 1 | One-cycle pulse: enter power-save |
| div_sel | input | 3 | Power-save divisor select (D = 2^(sel+1), capped at 128) |
| irq | input | 1 | Interrupt request |
| bus_t3 | input | 1 | Bus state indicator: the coming processor period is T3 |
| out_en | input | 2 | Per-output drive enable |
| out_pll | input | 2 | Per-output source: 1 = PLL rate, 0 = processor clock |
| cpu_ce | output | 1 | One-cycle enable at each processor-clock rising edge |
| clk_out | output | 2 | External clock outputs |

## Verification
A software entry into power-save and an interrupt-driven exit can fall on the same period boundary. The bench provokes this in two steps. It first times the end of a divided period from the last `cpu_ce`. It then drives `ps_set`, `irq` and `bus_t3` together in exactly that period's last cycle. The outcome is judged by the length of the next period: twice the divisor means the set won, and 2 cycles would show that the exit was taken. The same timing without `ps_set` is run as well, to confirm that the lone exit does switch to full rate at that edge.

// File: rtl/psclk_pkg.sv
package psclk_pkg;

  typedef enum logic {
    SRC_PROC = 1'b0,
    SRC_PLL  = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic     en;
    clk_src_e src;
  } out_cfg_t;

endpackage

// File: rtl/psclk_phase.sv
// Period counter: produces the processor clock level, the PLL-rate level
// and the rising-edge enable. The half-period changes only at a boundary.
module psclk_phase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] half_nxt,
  output logic         end_p,
  output logic         pclk_n,
  output logic         pll_n,
  output logic         pll_q,
  output logic         ce_q
);

  logic [W-1:0] cnt_q, cnt_n;
  logic [W-1:0] half_q, half_n;
  logic         pclk_q;
  logic [W:0]   last_idx;

  always_comb begin
    last_idx = {half_q, 1'b0} - (W+1)'(1);
    end_p    = ({1'b0, cnt_q} == last_idx);
    if (end_p) begin
      cnt_n  = '0;
      half_n = half_nxt;
    end else begin
      cnt_n  = cnt_q + W'(1);
      half_n = half_q;
    end
    pclk_n = (cnt_n < half_n);
    pll_n  = ~pll_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= W'(1);
      half_q <= W'(1);
      pclk_q <= 1'b0;
      pll_q  <= 1'b0;
      ce_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      half_q <= half_n;
      pclk_q <= pclk_n;
      pll_q  <= pll_n;
      ce_q   <= end_p;
    end
  end

endmodule

// File: rtl/psclk_mode.sv
// Power-save mode state: set by software, cleared by a pending interrupt
// at a period boundary entering T3. A set in the same cycle wins.
module psclk_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic end_p,
  input  logic ps_set,
  input  logic irq,
  input  logic bus_t3,
  output logic mode_q,
  output logic mode_n,
  output logic pend_q
);

  logic pend_n;
  logic leave;

  always_comb begin
    leave = end_p & mode_q & (pend_q | irq) & bus_t3;
    if (ps_set)     mode_n = 1'b1;
    else if (leave) mode_n = 1'b0;
    else            mode_n = mode_q;
    if (leave)      pend_n = 1'b0;
    else            pend_n = mode_q & (pend_q | irq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      pend_q <= pend_n;
    end
  end

endmodule

// File: rtl/psclk_outsel.sv
// One clock output: source and enable latched at the period boundary,
// output registered so every phase is whole.
module psclk_outsel
  import psclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic end_p,
  input  logic en,
  input  logic use_pll,
  input  logic pclk_n,
  input  logic pll_n,
  output logic clk_o
);

  out_cfg_t cfg_q, cfg_n;
  logic     o_n;

  always_comb begin
    if (end_p) begin
      cfg_n.en  = en;
      cfg_n.src = use_pll ? SRC_PLL : SRC_PROC;
    end else begin
      cfg_n = cfg_q;
    end
    o_n = cfg_n.en & ((cfg_n.src == SRC_PLL) ? pll_n : pclk_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.en  <= 1'b1;
      cfg_q.src <= SRC_PROC;
      clk_o     <= 1'b0;
    end else begin
      cfg_q <= cfg_n;
      clk_o <= o_n;
    end
  end

endmodule

// File: rtl/psave_clkgen.sv
module psave_clkgen #(
  parameter int NUM_OUT = 2,
  parameter int DIV_W   = 3,
  parameter int MAX_LOG = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ps_set,
  input  logic [DIV_W-1:0]   div_sel,
  input  logic               irq,
  input  logic               bus_t3,
  input  logic [NUM_OUT-1:0] out_en,
  input  logic [NUM_OUT-1:0] out_pll,
  output logic               cpu_ce,
  output logic [NUM_OUT-1:0] clk_out
);

  localparam int W       = MAX_LOG + 1;
  localparam int SEL_CAP = MAX_LOG - 1;

  logic         end_p;
  logic         pclk_n;
  logic         pll_n;
  logic         pll_q;
  logic         ps_mode_q;
  logic         ps_mode_n;
  logic         irq_pend_q;
  logic [W-1:0] half_sel;
  logic [W-1:0] half_nxt;

  always_comb begin
    if (int'(div_sel) >= SEL_CAP) half_sel = W'(1) << MAX_LOG;
    else                          half_sel = W'(1) << (int'(div_sel) + 1);
    half_nxt = ps_mode_n ? half_sel : W'(1);
  end

  psclk_mode u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .end_p  (end_p),
    .ps_set (ps_set),
    .irq    (irq),
    .bus_t3 (bus_t3),
    .mode_q (ps_mode_q),
    .mode_n (ps_mode_n),
    .pend_q (irq_pend_q)
  );

  psclk_phase #(.W(W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_nxt (half_nxt),
    .end_p    (end_p),
    .pclk_n   (pclk_n),
    .pll_n    (pll_n),
    .pll_q    (pll_q),
    .ce_q     (cpu_ce)
  );

  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
    psclk_outsel u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .end_p   (end_p),
      .en      (out_en[gi]),
      .use_pll (out_pll[gi]),
      .pclk_n  (pclk_n),
      .pll_n   (pll_n),
      .clk_o   (clk_out[gi])
    );
  end

endmodule

// File: rtl/psclk_chk.sv
module psclk_chk #(
  parameter int NUM_OUT = 2,
  parameter int MAX_LOG = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               bus_t3,
  input logic               cpu_ce,
  input logic [NUM_OUT-1:0] clk_out,
  input logic               pll_lvl,
  input logic               mode,
  input logic               pend
);

  localparam int LIMIT = 2 ** (MAX_LOG + 1);
  localparam int GW    = MAX_LOG + 2;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (cpu_ce) gap_q <= '0;
    else if (gap_q != {GW{1'b1}}) gap_q <= gap_q + GW'(1);
  end

  AST_CE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |=> !cpu_ce); // R10

  AST_CE_ON_PLL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> pll_lvl); // R10

  AST_CE_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap_q) < LIMIT); // R10

  AST_EXIT_AT_T3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode) |-> ($past(bus_t3) && $past(pend || irq))); // R5

  AST_EXIT_NEW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode) |-> cpu_ce); // R5

  AST_NO_PEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !pend) |=> !pend); // R6

  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_chk
    AST_OUT_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out[gi]) |-> pll_lvl); // R9
  end

endmodule

bind psave_clkgen psclk_chk #(.NUM_OUT(NUM_OUT), .MAX_LOG(MAX_LOG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .bus_t3  (bus_t3),
  .cpu_ce  (cpu_ce),
  .clk_out (clk_out),
  .pll_lvl (pll_q),
  .mode    (ps_mode_q),
  .pend    (irq_pend_q)
);

// File: tb/test_psave_clkgen.sv
`timescale 1ns/1ps
module test_psave_clkgen;

  logic       clk;
  logic       rst_n;
  logic       ps_set;
  logic [2:0] div_sel;
  logic       irq;
  logic       bus_t3;
  logic [1:0] out_en;
  logic [1:0] out_pll;
  logic       cpu_ce;
  logic [1:0] clk_out;

  int n_chk;
  int n_fail;
  int per;
  int hi;

  psave_clkgen i_psave_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .ps_set  (ps_set),
    .div_sel (div_sel),
    .irq     (irq),
    .bus_t3  (bus_t3),
    .out_en  (out_en),
    .out_pll (out_pll),
    .cpu_ce  (cpu_ce),
    .clk_out (clk_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int div_of(input int s);
    return (s >= 6) ? 128 : (2 ** (s + 1));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ce();
    while (!cpu_ce) @(negedge clk);
  endtask

  // Measures one processor period from a cpu_ce to the next. If new_sel
  // is not negative it is applied one cycle into the period.
  task automatic measure(input int new_sel, output int p, output int h);
    wait_ce();
    p = 0;
    h = 0;
    do begin
      h += int'(clk_out[0]);
      p++;
      @(negedge clk);
      if (new_sel >= 0 && p == 1) div_sel = 3'(new_sel);
    end while (!cpu_ce);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; ps_set = 1'b0; div_sel = 3'd0; irq = 1'b0; bus_t3 = 1'b0;
    out_en = 2'b11; out_pll = 2'b00;
    repeat (5) @(negedge clk);
    check("R1 ce in reset", int'(cpu_ce), 0);
    check("R1 outputs in reset", int'(clk_out), 0);
    rst_n = 1'b1;

    measure(-1, per, hi);
    check("R1 period after reset", per, 2);
    check("R2 high phase full rate", hi, 1);
    for (int k = 0; k < 8; k++) begin
      check("R2 out0 follows ce", int'(clk_out[0]), int'(cpu_ce));
      @(negedge clk);
    end

    // R6: interrupt outside power-save is dropped
    irq = 1'b1; bus_t3 = 1'b1;
    repeat (4) @(negedge clk);
    irq = 1'b0;
    div_sel = 3'd1; ps_set = 1'b1;
    @(negedge clk);
    ps_set = 1'b0;
    measure(-1, per, hi);
    measure(-1, per, hi);
    check("R6 no exit after stale irq", per, 8);
    bus_t3 = 1'b0;

    // R3: divisor sweep
    for (int s = 0; s < 8; s++) begin
      div_sel = 3'(s);
      measure(-1, per, hi);
      measure(-1, per, hi);
      check("R3 period", per, 2 * div_of(s));
      check("R3 high phase", hi, div_of(s));
    end

    // R4: mid-period change keeps the running period
    div_sel = 3'd2;
    measure(-1, per, hi);
    measure(-1, per, hi);
    measure(0, per, hi);
    check("R4 running period kept", per, 16);
    check("R4 running high kept", hi, 8);
    measure(2, per, hi);
    check("R4 new divisor next period", per, 4);
    measure(-1, per, hi);
    check("R4 restored divisor", per, 16);

    // R8: out1 at PLL rate while out0 divided
    out_pll = 2'b10;
    measure(-1, per, hi);
    begin
      logic prev;
      int   toggles;
      prev = clk_out[1];
      toggles = 0;
      for (int k = 0; k < 32; k++) begin
        @(negedge clk);
        if (clk_out[1] != prev) toggles++;
        prev = clk_out[1];
      end
      check("R8 out1 toggles every cycle", toggles, 32);
    end
    measure(-1, per, hi);
    check("R8 out0 divided meanwhile", per, 16);
    check("R8 out0 high meanwhile", hi, 8);
    out_pll = 2'b00;

    // R9: disable mid-period
    wait_ce();
    @(negedge clk);
    out_en[0] = 1'b0;
    @(negedge clk);
    check("R9 phase kept after mid-period disable", int'(clk_out[0]), 1);
    wait_ce();
    @(negedge clk);
    wait_ce();
    begin
      int highs;
      highs = 0;
      for (int k = 0; k < 32; k++) begin
        highs += int'(clk_out[0]);
        @(negedge clk);
      end
      check("R9 disabled output low", highs, 0);
    end
    out_en[0] = 1'b1;
    measure(-1, per, hi);

    // R5: pending interrupt waits for T3
    @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    measure(-1, per, hi);
    check("R5 no exit without T3", per, 16);
    bus_t3 = 1'b1;
    measure(-1, per, hi);
    measure(-1, per, hi);
    check("R5 full rate after T3 exit", per, 2);
    bus_t3 = 1'b0;
    measure(-1, per, hi);
    measure(-1, per, hi);
    check("R5 stays full rate", per, 2);

    // R7: set and exit in the same boundary cycle
    div_sel = 3'd1;
    ps_set = 1'b1;
    @(negedge clk);
    ps_set = 1'b0;
    measure(-1, per, hi);
    measure(-1, per, hi);
    wait_ce();
    repeat (7) @(negedge clk);
    irq = 1'b1; bus_t3 = 1'b1; ps_set = 1'b1;
    @(negedge clk);
    irq = 1'b0; bus_t3 = 1'b0; ps_set = 1'b0;
    check("R7 boundary reached", int'(cpu_ce), 1);
    measure(-1, per, hi);
    check("R7 set wins over exit", per, 8);
    bus_t3 = 1'b1;
    measure(-1, per, hi);
    check("R7 pending cleared", per, 8);
    bus_t3 = 1'b0;

    // R5: lone exit at a timed boundary
    wait_ce();
    repeat (7) @(negedge clk);
    irq = 1'b1; bus_t3 = 1'b1;
    @(negedge clk);
    irq = 1'b0; bus_t3 = 1'b0;
    measure(-1, per, hi);
    check("R5 exit at timed boundary", per, 2);

    finish_run();
  end

endmodule